// File: doc/BRIEF.md
# Single-Wire ROM Command Layer

This block is the addressing stage of a single-wire slave. It sits between a bit engine, which turns wire activity into reset events and read or write slots, and the memory command layer. After each bus reset it collects an 8-bit command, least significant bit first. Depending on that code, it reads out its 64-bit identity, compares the master's 64 bits against it, joins the bitwise search arbitration, or skips addressing. It then raises a hand-off level that passes the following slots to the memory layer.

The identity is set by two parameters, a family byte and a 48-bit serial field. The block computes the closing check byte itself at elaboration time. Two flags persist across bus resets. The resume flag records that this slave was the one last selected. The overdrive flag selects the fast slot timing in the bit engine. Only a bus reset of standard length clears the overdrive flag.

Top module: `swr_rom_layer`

## Requirements
- R1: After `rst_n` deasserts, `od_o`, `rc_o` and `mem_active_o` are 0 and `tx_bit_o` is 1. Write slots are ignored until the first bus reset.
- R2: Code 33h makes the block answer 64 read slots with its identity, least significant bit first. Bits 0..7 are the family byte, bits 8..55 the serial field and bits 56..63 the check byte. After the 64th slot `mem_active_o` rises and `rc_o` is 0.
- R3: The check byte is the CRC-8 of the 56 data bits for x^8+x^5+x^4+1, with a zero start and data taken least significant bit first. Running all 64 identity bits through the same register leaves zero.
- R4: Code 55h takes 64 write slots. If all 64 equal the identity, `rc_o` becomes 1 and `mem_active_o` rises. On the first unequal bit, `rc_o` becomes 0 and every slot is ignored until a bus reset.
- R5: Code F0h runs 64 rounds of three slots. Two read slots return the identity bit and then its complement, and a write slot carries the master's direction bit. If the direction differs from the identity bit, `rc_o` becomes 0 and the block goes quiet until reset. After 64 agreeing rounds, `rc_o` becomes 1 and `mem_active_o` rises.
- R6: Code CCh raises `mem_active_o` at once and clears `rc_o`.
- R7: Code A5h raises `mem_active_o` only when `rc_o` is 1. Otherwise the block goes quiet until reset.
- R8: Code 3Ch sets `od_o` to 1, clears `rc_o` and raises `mem_active_o`.
- R9: Code 69h sets `od_o` to 1 when the command completes, then matches 64 bits as in R4. On a mismatch, `od_o` goes back to the value it had before the command.
- R10: A bus reset drops `mem_active_o` and restarts command collection. With `reset_std_i` = 1 it also clears `od_o`; with `reset_std_i` = 0 it leaves `od_o` unchanged.
- R11: Any other command code makes the block ignore all slots until the next bus reset: `tx_bit_o` stays 1 and `mem_active_o` stays 0.
- R12: A command byte is assembled least significant bit first from eight write slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| bus_reset_i | input | 1 | One-cycle pulse: bus reset seen on the wire |
| reset_std_i | input | 1 | Qualifies `bus_reset_i`: 1 for a standard-length reset |
| wr_slot_i | input | 1 | One-cycle pulse: master write slot completed |
| wr_bit_i | input | 1 | Bit value of the write slot |
| rd_slot_i | input | 1 | One-cycle pulse: master read slot; `tx_bit_o` is the bit shown in it |
| tx_bit_o | output | 1 | Bit to show in the next read slot (1 = released) |
| mem_active_o | output | 1 | Slots now belong to the memory layer |
| od_o | output | 1 | Overdrive speed selected |
| rc_o | output | 1 | Resume flag: this slave was last selected |

## Verification
The identity is read back with a family byte and a serial field chosen so that bits vary along the word. It is compared with a check byte that the bench computes with its own shift-register model, which separates a wrong polynomial or a wrong bit order from a correct one. Match and overdrive-match are driven with the exact identity and with a single bit flipped at the first position, in the middle and at the last position. This shows whether the compare is done on every bit and whether the overdrive flag returns to its earlier value. Search is run with the correct direction on every round and with a wrong direction midway, which checks the true/complement pair and the drop-out. Resume is tried after a selecting command and after a non-selecting one. Reset length is varied to show which resets clear overdrive.

// File: rtl/swr_pkg.sv
package swr_pkg;
  localparam int FAM_W  = 8;
  localparam int SER_W  = 48;
  localparam int CHK_W  = 8;
  localparam int DATA_W = FAM_W + SER_W;
  localparam int ID_W   = DATA_W + CHK_W;
  localparam int IDX_W  = $clog2(ID_W);

  localparam logic [7:0] OP_READ   = 8'h33;
  localparam logic [7:0] OP_MATCH  = 8'h55;
  localparam logic [7:0] OP_SEARCH = 8'hF0;
  localparam logic [7:0] OP_SKIP   = 8'hCC;
  localparam logic [7:0] OP_RESUME = 8'hA5;
  localparam logic [7:0] OP_ODSKIP = 8'h3C;
  localparam logic [7:0] OP_ODMTCH = 8'h69;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_SEND, ST_MATCH,
    ST_S_TRUE, ST_S_CMPL, ST_S_DIR, ST_MEM
  } rom_state_t;

  // Reflected form of x^8+x^5+x^4+1, one bit per step, LSB first.
  function automatic logic [CHK_W-1:0] chk8_step(input logic [CHK_W-1:0] c,
                                                 input logic b);
    logic fb;
    fb = c[0] ^ b;
    chk8_step = (c >> 1) ^ (fb ? 8'h8C : 8'h00);
  endfunction

  function automatic logic [CHK_W-1:0] chk8_of(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = '0;
    for (int i = 0; i < DATA_W; i++) c = chk8_step(c, d[i]);
    chk8_of = c;
  endfunction
endpackage

// File: rtl/swr_id_rom.sv
module swr_id_rom
  import swr_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY = 8'h23,
  parameter logic [SER_W-1:0] SERIAL = 48'h0000_1A2B_3C4D
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic             id_bit_o
);
  localparam logic [DATA_W-1:0] DATA  = {SERIAL, FAMILY};
  localparam logic [CHK_W-1:0]  CHECK = chk8_of(DATA);
  localparam logic [ID_W-1:0]   IDENT = {CHECK, DATA};

  assign id_bit_o = IDENT[idx_i];
endmodule

// File: rtl/swr_cursor.sv
module swr_cursor
  import swr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ID_W - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_o <= '0;
    else if (clr_i)  idx_o <= '0;
    else if (adv_i)  idx_o <= idx_o + 1'b1;
  end

  assign last_o = (idx_o == LAST);

  p_cursor_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clr_i && !last_o) |=> (idx_o == $past(idx_o) + 1'b1));
endmodule

// File: rtl/swr_flags.sv
module swr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic std_clr_i,
  input  logic od_set_i,
  input  logic od_restore_i,
  input  logic rc_set_i,
  input  logic rc_clr_i,
  output logic od_o,
  output logic rc_o
);
  logic od_before;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      od_o      <= 1'b0;
      od_before <= 1'b0;
      rc_o      <= 1'b0;
    end else begin
      if (std_clr_i) begin
        od_o <= 1'b0;
      end else if (od_set_i) begin
        od_before <= od_o;
        od_o      <= 1'b1;
      end else if (od_restore_i) begin
        od_o <= od_before;
      end
      if (rc_set_i)      rc_o <= 1'b1;
      else if (rc_clr_i) rc_o <= 1'b0;
    end
  end

  p_od_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (od_set_i && !std_clr_i) |=> od_o);
  p_rc_events_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rc_set_i && rc_clr_i));
endmodule

// File: rtl/swr_rom_layer.sv
module swr_rom_layer
  import swr_pkg::*;
#(
  parameter logic [FAM_W-1:0] FAMILY = 8'h23,
  parameter logic [SER_W-1:0] SERIAL = 48'h0000_1A2B_3C4D
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset_i,
  input  logic reset_std_i,
  input  logic wr_slot_i,
  input  logic wr_bit_i,
  input  logic rd_slot_i,
  output logic tx_bit_o,
  output logic mem_active_o,
  output logic od_o,
  output logic rc_o
);
  rom_state_t       state, next_after_cmd;
  logic [2:0]       cmd_cnt;
  logic [7:0]       cmd_sr;
  logic [7:0]       cmd_code;
  logic             odm_mode;
  logic [IDX_W-1:0] idx;
  logic             idx_last, id_bit;

  // Named internal events
  logic wr_ev, rd_ev, cmd_done, id_step, id_miss, id_ok_done;
  logic rc_set, rc_clr, od_set, od_restore, std_clr;

  assign wr_ev    = wr_slot_i && !bus_reset_i;
  assign rd_ev    = rd_slot_i && !bus_reset_i;
  assign cmd_code = {wr_bit_i, cmd_sr[7:1]};
  assign cmd_done = (state == ST_CMD) && wr_ev && (cmd_cnt == 3'd7);

  assign id_step  = ((state == ST_SEND)  && rd_ev) ||
                    ((state == ST_MATCH) && wr_ev) ||
                    ((state == ST_S_DIR) && wr_ev);
  assign id_miss  = wr_ev && ((state == ST_MATCH) || (state == ST_S_DIR)) &&
                    (wr_bit_i != id_bit);
  assign id_ok_done = wr_ev && ((state == ST_MATCH) || (state == ST_S_DIR)) &&
                      (wr_bit_i == id_bit) && idx_last;

  always_comb begin
    case (cmd_code)
      OP_READ:   next_after_cmd = ST_SEND;
      OP_MATCH:  next_after_cmd = ST_MATCH;
      OP_ODMTCH: next_after_cmd = ST_MATCH;
      OP_SEARCH: next_after_cmd = ST_S_TRUE;
      OP_SKIP:   next_after_cmd = ST_MEM;
      OP_ODSKIP: next_after_cmd = ST_MEM;
      OP_RESUME: next_after_cmd = rc_o ? ST_MEM : ST_IDLE;
      default:   next_after_cmd = ST_IDLE;
    endcase
  end

  assign rc_set     = id_ok_done;
  assign rc_clr     = id_miss ||
                      (cmd_done && (cmd_code == OP_READ || cmd_code == OP_SKIP ||
                                    cmd_code == OP_ODSKIP));
  assign od_set     = cmd_done && (cmd_code == OP_ODSKIP || cmd_code == OP_ODMTCH);
  assign od_restore = id_miss && odm_mode && (state == ST_MATCH);
  assign std_clr    = bus_reset_i && reset_std_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cmd_cnt  <= '0;
      cmd_sr   <= '0;
      odm_mode <= 1'b0;
    end else if (bus_reset_i) begin
      state    <= ST_CMD;
      cmd_cnt  <= '0;
      odm_mode <= 1'b0;
    end else begin
      case (state)
        ST_CMD: if (wr_ev) begin
          cmd_sr  <= cmd_code;
          cmd_cnt <= cmd_cnt + 1'b1;
          if (cmd_done) begin
            state    <= next_after_cmd;
            odm_mode <= (cmd_code == OP_ODMTCH);
          end
        end
        ST_SEND:   if (rd_ev && idx_last) state <= ST_MEM;
        ST_MATCH:  if (wr_ev) begin
          if (id_miss)       state <= ST_IDLE;
          else if (idx_last) state <= ST_MEM;
        end
        ST_S_TRUE: if (rd_ev) state <= ST_S_CMPL;
        ST_S_CMPL: if (rd_ev) state <= ST_S_DIR;
        ST_S_DIR:  if (wr_ev) begin
          if (id_miss)       state <= ST_IDLE;
          else if (idx_last) state <= ST_MEM;
          else               state <= ST_S_TRUE;
        end
        default: state <= state;
      endcase
    end
  end

  swr_cursor u_cursor (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (cmd_done || bus_reset_i),
    .adv_i  (id_step),
    .idx_o  (idx),
    .last_o (idx_last)
  );

  swr_id_rom #(.FAMILY(FAMILY), .SERIAL(SERIAL)) u_id (
    .idx_i    (idx),
    .id_bit_o (id_bit)
  );

  swr_flags u_flags (
    .clk          (clk),
    .rst_n        (rst_n),
    .std_clr_i    (std_clr),
    .od_set_i     (od_set),
    .od_restore_i (od_restore),
    .rc_set_i     (rc_set),
    .rc_clr_i     (rc_clr),
    .od_o         (od_o),
    .rc_o         (rc_o)
  );

  always_comb begin
    case (state)
      ST_SEND, ST_S_TRUE: tx_bit_o = id_bit;
      ST_S_CMPL:          tx_bit_o = ~id_bit;
      default:            tx_bit_o = 1'b1;
    endcase
  end

  assign mem_active_o = (state == ST_MEM);

  p_mem_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset_i |=> !mem_active_o);
  p_od_std_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_reset_i && reset_std_i) |=> !od_o);
  p_cmpl_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_S_TRUE && rd_ev) |=> (tx_bit_o != $past(tx_bit_o)));
  p_rc_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rc_o) |-> $past(id_ok_done));
  p_resume_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_done && cmd_code == OP_RESUME) |=> (mem_active_o == $past(rc_o)));
  p_miss_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (id_miss && !bus_reset_i) |=> (tx_bit_o && !mem_active_o));
endmodule

// File: tb/tb_swr_rom_layer.sv
`timescale 1ns/1ps
module tb_swr_rom_layer;
  localparam logic [7:0]  FAM = 8'h23;
  localparam logic [47:0] SER = 48'hB7_0C_5E_91_A4_36;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_reset_i = 0, reset_std_i = 0, wr_slot_i = 0, wr_bit_i = 0, rd_slot_i = 0;
  logic tx_bit_o, mem_active_o, od_o, rc_o;
  int   total = 0, bad = 0;
  logic [63:0] exp_id;
  bit   finished = 0;

  always #10 clk = ~clk;

  swr_rom_layer #(.FAMILY(FAM), .SERIAL(SER)) dut (
    .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset_i), .reset_std_i(reset_std_i),
    .wr_slot_i(wr_slot_i), .wr_bit_i(wr_bit_i), .rd_slot_i(rd_slot_i),
    .tx_bit_o(tx_bit_o), .mem_active_o(mem_active_o), .od_o(od_o), .rc_o(rc_o));

  // Bench's own model: shift register, feedback into stages 7, 3 and 2.
  function automatic logic [7:0] model_crc(input logic [63:0] v, input int n);
    logic [7:0] s;
    logic f;
    s = 8'h00;
    for (int i = 0; i < n; i++) begin
      f = s[0] ^ v[i];
      s = {f, s[7:1]};
      s[3] = s[3] ^ f;
      s[2] = s[2] ^ f;
    end
    return s;
  endfunction

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wslot(input logic b);
    @(negedge clk); wr_slot_i = 1; wr_bit_i = b;
    @(negedge clk); wr_slot_i = 0;
  endtask

  task automatic rslot(output logic b);
    @(negedge clk); b = tx_bit_o; rd_slot_i = 1;
    @(negedge clk); rd_slot_i = 0;
  endtask

  task automatic breset(input logic std);
    @(negedge clk); bus_reset_i = 1; reset_std_i = std;
    @(negedge clk); bus_reset_i = 0; reset_std_i = 0;
  endtask

  task automatic send_cmd(input logic [7:0] c);   // R12: LSB first
    for (int i = 0; i < 8; i++) wslot(c[i]);
  endtask

  task automatic send_id(input int flip);         // flip < 0: exact identity
    for (int i = 0; i < 64; i++) wslot(exp_id[i] ^ (i == flip));
  endtask

  task automatic t_reset_state();
    chk({rc_o, od_o, mem_active_o, tx_bit_o}, 4'b0001, "R1 reset outputs");
    send_cmd(8'hCC);
    chk(mem_active_o, 0, "R1 writes before bus reset ignored");
  endtask

  task automatic t_read_rom();
    logic [63:0] got;
    logic b;
    breset(1); send_cmd(8'h33);
    for (int i = 0; i < 64; i++) begin
      chk(mem_active_o, 0, "R2 not handed over during read-out");
      rslot(b); got[i] = b;
    end
    chk(got, exp_id, "R2 identity read LSB first");
    chk(got[7:0], FAM, "R2 family byte first");
    chk(model_crc(got, 56), got[63:56], "R3 check byte");
    chk(model_crc(got, 64), 0, "R3 full identity closes to zero");
    chk({mem_active_o, rc_o}, 2'b10, "R2 handover with rc cleared");
  endtask

  task automatic t_match(input int flip);
    logic b;
    breset(1); send_cmd(8'h55); send_id(flip);
    if (flip < 0) chk({mem_active_o, rc_o}, 2'b11, "R4 full match selects");
    else begin
      chk({mem_active_o, rc_o}, 2'b00, "R4 mismatch drops");
      send_cmd(8'hCC); rslot(b);
      chk({mem_active_o, b}, 2'b01, "R4 slots ignored after mismatch");
    end
  endtask

  task automatic t_search(input int bad_at);
    logic t, c, b;
    breset(1); send_cmd(8'hF0);
    for (int i = 0; i < 64; i++) begin
      rslot(t); rslot(c);
      chk({t, c}, {exp_id[i], ~exp_id[i]}, "R5 true/complement pair");
      wslot(exp_id[i] ^ (i == bad_at));
      if (i == bad_at) break;
    end
    if (bad_at < 0) chk({mem_active_o, rc_o}, 2'b11, "R5 search win selects");
    else begin
      chk({mem_active_o, rc_o}, 2'b00, "R5 search loss clears rc");
      rslot(b); rslot(c);
      chk({b, c}, 2'b11, "R5 released after drop-out");
    end
  endtask

  task automatic t_skip_resume();
    breset(1); send_cmd(8'h55); send_id(-1);
    breset(1); send_cmd(8'hA5);
    chk({mem_active_o, rc_o}, 2'b11, "R7 resume with rc set");
    breset(1); send_cmd(8'hCC);
    chk({mem_active_o, rc_o}, 2'b10, "R6 skip hands over, clears rc");
    breset(1); send_cmd(8'hA5);
    chk(mem_active_o, 0, "R7 resume refused with rc clear");
    send_cmd(8'hCC);
    chk(mem_active_o, 0, "R7 quiet after refused resume");
  endtask

  task automatic t_overdrive();
    breset(1); send_cmd(8'h55); send_id(-1);
    breset(1); send_cmd(8'h3C);
    chk({mem_active_o, od_o, rc_o}, 3'b110, "R8 overdrive skip");
    breset(0);
    chk({mem_active_o, od_o}, 2'b01, "R10 short reset keeps od, drops mem");
    send_cmd(8'h69);
    chk(od_o, 1, "R9 od set after od-match code");
    send_id(63);
    chk({od_o, rc_o, mem_active_o}, 3'b100, "R9 mismatch keeps od already set");
    breset(1);
    chk(od_o, 0, "R10 standard reset clears od");
    send_cmd(8'h69);
    chk(od_o, 1, "R9 od set from standard speed");
    send_id(20);
    chk({od_o, rc_o}, 2'b00, "R9 mismatch restores od to 0");
    breset(1); send_cmd(8'h69); send_id(-1);
    chk({od_o, rc_o, mem_active_o}, 3'b111, "R9 od-match success");
    breset(1);
  endtask

  task automatic t_unknown();
    logic b;
    breset(1); send_cmd(8'h5A);
    chk(mem_active_o, 0, "R11 unknown code idle");
    send_cmd(8'hCC); rslot(b);
    chk({mem_active_o, b}, 2'b01, "R11 slots ignored until reset");
    breset(1); send_cmd(8'hCC);
    chk(mem_active_o, 1, "R11 recovers after reset");
  endtask

  initial begin
    exp_id[55:0]  = {SER, FAM};
    exp_id[63:56] = 8'h00;
    exp_id[63:56] = model_crc(exp_id, 56);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_read_rom();
    t_match(-1); t_match(0); t_match(33); t_match(63);
    t_search(-1); t_search(17);
    t_skip_resume();
    t_overdrive();
    t_unknown();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule